// File: doc/BRIEF.md
# Manchester Level-Stream Decoder with Preamble Abort

This block sits behind a data slicer and a level classifier. Each token it receives describes one constant level on the line: its duration class and whether the line was high or low. The decoder turns those tokens back into data bits. A message opens with a preamble, then a start bit, then a bit-stuffed body. A bit is coded as its first half-cell level: a 1 is high then low, a 0 is low then high.

The preamble is a run of long levels longer than any stuffed body can hold. The run counter that finds it never stops watching, even while a message is being decoded. A strong new transmission can therefore cut off a weak or corrupted one, which is dropped with an abort pulse. Stuffed bits are removed before bits leave the block. A stuffed bit that breaks the rule, an invalid token, or a long level that begins on a bit boundary also drops the message.

Tokens arrive on a valid/ready input and bits leave on a valid/ready output. A token is taken when `tok_valid` and `tok_ready` are both high. `tok_ready` goes low only while a decoded bit is waiting and `bit_ready` is low. A waiting bit stays on `bit_data` until it is accepted. `msg_start` and `abort_pulse` are plain one-cycle strobes, raised in the cycle after the token that causes them.

Top module: `mld_decoder`

## Requirements
- R1: After reset `bit_valid`, `msg_start` and `abort_pulse` are low, `tok_ready` is high, and the decoder is hunting, so no message can begin until a preamble has been seen.
- R2: `tok_class` codes 2'b00 as a short level (half a bit cell) and 2'b01 as a long level (a full bit cell); both 2'b10 and 2'b11 mean invalid. `tok_lvl` is the line level, 1 for high.
- R3: In any state, the 15th consecutive accepted long level puts the decoder in the preamble state. A run of 14 does not.
- R4: In the preamble state a short level of the wrong polarity (low) is ignored. A high short level followed by a low level forms the start bit, and `msg_start` pulses one cycle after that second level.
- R5: Data bits are emitted in line order, each equal to its first half-cell level. Each bit appears on `bit_data` one cycle after the token that completes it. Up to 14 long levels in a row inside a message decode as plain data.
- R6: After 7 equal data bits the next bit is a stuffed bit and is never emitted. If that stuffed bit equals the previous 7, the message is dropped.
- R7: A preamble found in the middle of a message drops it with an abort pulse on the 15th long level, and the next message then decodes normally.
- R8: An invalid token inside a message drops it and returns the decoder to hunting. An invalid token while hunting or in the preamble state gives no abort.
- R9: A long level that starts on a bit boundary drops the message.
- R10: While a bit is waiting and `bit_ready` is low, `tok_ready` is low and `bit_valid`/`bit_data` hold steady. One cycle after `bit_ready` rises, the bit is gone and `tok_ready` is high again.
- R11: Any short or invalid level clears the long-level run, so two runs of 10 longs separated by one short level do not make a preamble.
- R12: Every message that is dropped gives exactly one `abort_pulse`, never in the same cycle as `msg_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Level token present |
| tok_ready | output | 1 | Decoder can take a token |
| tok_class | input | 2 | Level duration class |
| tok_lvl | input | 1 | Line level of the token |
| bit_valid | output | 1 | Decoded bit present |
| bit_ready | input | 1 | Downstream takes the bit |
| bit_data | output | 1 | Decoded data bit |
| msg_start | output | 1 | One-cycle pulse when a start bit completes |
| abort_pulse | output | 1 | One-cycle pulse when a partial message is dropped |

## Verification
Stimulus is written as bit vectors, which the bench turns into alternating short and long levels. Five vectors are used:
- A mixed pattern checks plain bit recovery.
- Runs of seven ones and of seven zeros show that a stuffed bit is removed in both polarities.
- A fully alternating pattern keeps 14 long levels inside a message and shows that this does not count as a preamble.

Directed sequences cover the remaining cases:
- Long runs of 14 and of 15 levels, and runs split by a short level.
- A preamble injected into a stream of alternating bits.
- A stuffing violation, an invalid token, and a long level on a bit boundary.
- A wrong-polarity short level before the start bit.
- A stalled output.

// File: rtl/mld_pkg.sv
package mld_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_PRE,
    ST_SBIT,
    ST_EDGE,
    ST_MID
  } mld_state_e;

  localparam logic [1:0] CLS_SHORT = 2'b00;
  localparam logic [1:0] CLS_LONG  = 2'b01;

endpackage

// File: rtl/mld_run_counter.sv
module mld_run_counter #(
  parameter int PRE_LONGS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic is_long,
  output logic pre_hit
);
  localparam int CW = $clog2(PRE_LONGS + 1);
  localparam logic [CW-1:0] RUN_CAP  = CW'(PRE_LONGS);
  localparam logic [CW-1:0] RUN_TRIG = CW'(PRE_LONGS - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (step) begin
      if (!is_long)              run_q <= '0;
      else if (run_q != RUN_CAP) run_q <= run_q + 1'b1;
    end
  end

  assign pre_hit = step && is_long && (run_q >= RUN_TRIG);

  AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !is_long) |=> (run_q == '0)); // R11

  AST_RUN_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_long && run_q == RUN_CAP) |=> (run_q == RUN_CAP)); // R3

endmodule

// File: rtl/mld_destuff.sv
module mld_destuff #(
  parameter int MAX_EQ = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic in_valid,
  input  logic in_bit,
  output logic out_valid,
  output logic out_bit,
  output logic stuff_err
);
  localparam int QW = $clog2(MAX_EQ + 1);
  localparam logic [QW-1:0] EQ_LIM = QW'(MAX_EQ);

  logic [QW-1:0] eq_q;
  logic          last_q;
  logic          pending;

  assign pending   = (eq_q == EQ_LIM);
  assign out_valid = in_valid && !pending;
  assign out_bit   = in_bit;
  assign stuff_err = in_valid && pending && (in_bit == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q   <= '0;
      last_q <= 1'b0;
    end else if (clear) begin
      eq_q <= '0;
    end else if (in_valid) begin
      if (pending) begin
        if (!stuff_err) begin
          last_q <= in_bit;
          eq_q   <= QW'(1);
        end
      end else if (eq_q == '0 || in_bit != last_q) begin
        last_q <= in_bit;
        eq_q   <= QW'(1);
      end else begin
        eq_q <= eq_q + 1'b1;
      end
    end
  end

  AST_STUFF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clear && pending && !stuff_err) |=> (eq_q == QW'(1))); // R6

endmodule

// File: rtl/mld_bit_hold.sv
module mld_bit_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_bit,
  output logic can_take,
  output logic o_valid,
  input  logic o_ready,
  output logic o_data
);
  assign can_take = !o_valid || o_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= 1'b0;
    end else if (push) begin
      o_valid <= 1'b1;
      o_data  <= push_bit;
    end else if (o_ready) begin
      o_valid <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data))); // R10

endmodule

// File: rtl/mld_decoder.sv
module mld_decoder
  import mld_pkg::*;
#(
  parameter int   PRE_LONGS = 15,
  parameter int   MAX_EQ    = 7,
  parameter logic START_LVL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_valid,
  output logic       tok_ready,
  input  logic [1:0] tok_class,
  input  logic       tok_lvl,
  output logic       bit_valid,
  input  logic       bit_ready,
  output logic       bit_data,
  output logic       msg_start,
  output logic       abort_pulse
);
  mld_state_e state_q, nxt_a, nxt;
  logic first_q, first_n;
  logic acc, is_long, is_short, is_bad, busy;
  logic pre_hit, emit, clr, start_n, abort_a, abort_d;
  logic ds_valid, ds_bit, st_err;

  assign acc      = tok_valid && tok_ready;
  assign is_long  = (tok_class == CLS_LONG);
  assign is_short = (tok_class == CLS_SHORT);
  assign is_bad   = tok_class[1];
  assign busy     = (state_q == ST_SBIT) || (state_q == ST_EDGE) || (state_q == ST_MID);

  mld_run_counter #(.PRE_LONGS(PRE_LONGS)) u_run (
    .clk(clk), .rst_n(rst_n), .step(acc), .is_long(is_long), .pre_hit(pre_hit)
  );

  always_comb begin
    nxt_a   = state_q;
    first_n = first_q;
    start_n = 1'b0;
    abort_a = 1'b0;
    emit    = 1'b0;
    clr     = 1'b0;
    if (acc) begin
      if (pre_hit) begin
        nxt_a   = ST_PRE;
        abort_a = busy;
      end else if (is_bad) begin
        nxt_a   = ST_HUNT;
        abort_a = busy;
      end else begin
        unique case (state_q)
          ST_HUNT: nxt_a = ST_HUNT;
          ST_PRE: begin
            if (is_short && tok_lvl == START_LVL) nxt_a = ST_SBIT;
          end
          ST_SBIT: begin
            if (tok_lvl == START_LVL) begin
              nxt_a   = ST_HUNT;
              abort_a = 1'b1;
            end else begin
              start_n = 1'b1;
              clr     = 1'b1;
              if (is_long) begin
                nxt_a   = ST_MID;
                first_n = tok_lvl;
              end else begin
                nxt_a = ST_EDGE;
              end
            end
          end
          ST_EDGE: begin
            if (is_long) begin
              nxt_a   = ST_HUNT;
              abort_a = 1'b1;
            end else begin
              nxt_a   = ST_MID;
              first_n = tok_lvl;
            end
          end
          ST_MID: begin
            if (tok_lvl == first_q) begin
              nxt_a   = ST_HUNT;
              abort_a = 1'b1;
            end else begin
              emit = 1'b1;
              if (is_long) begin
                nxt_a   = ST_MID;
                first_n = tok_lvl;
              end else begin
                nxt_a = ST_EDGE;
              end
            end
          end
          default: nxt_a = ST_HUNT;
        endcase
      end
    end
  end

  mld_destuff #(.MAX_EQ(MAX_EQ)) u_destuff (
    .clk(clk), .rst_n(rst_n), .clear(clr), .in_valid(emit), .in_bit(first_q),
    .out_valid(ds_valid), .out_bit(ds_bit), .stuff_err(st_err)
  );

  assign nxt     = st_err ? ST_HUNT : nxt_a;
  assign abort_d = abort_a || st_err;

  mld_bit_hold u_hold (
    .clk(clk), .rst_n(rst_n), .push(ds_valid), .push_bit(ds_bit),
    .can_take(tok_ready), .o_valid(bit_valid), .o_ready(bit_ready), .o_data(bit_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_HUNT;
      first_q     <= 1'b0;
      msg_start   <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      state_q     <= nxt;
      first_q     <= first_n;
      msg_start   <= start_n;
      abort_pulse <= abort_d;
    end
  end

  AST_PRE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pre_hit) |=> (state_q == ST_PRE)); // R3

  AST_START_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start |-> (state_q == ST_EDGE || state_q == ST_MID)); // R4

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (state_q == ST_HUNT || state_q == ST_PRE)); // R12

  AST_NO_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_start && abort_pulse)); // R12

endmodule

// File: tb/test_mld_decoder.sv
module test_mld_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_valid = 1'b0;
  logic [1:0] tok_class = 2'b00;
  logic tok_lvl = 1'b0;
  logic bit_ready = 1'b1;
  logic tok_ready, bit_valid, bit_data, msg_start, abort_pulse;

  int nchk = 0, nbad = 0;
  int n_start = 0, n_abort = 0, ncap = 0;
  logic [31:0] cap = '0;
  logic cur_lvl = 1'b0;
  bit done = 1'b0;

  localparam logic [1:0] SHORT = 2'b00;
  localparam logic [1:0] LONG  = 2'b01;
  localparam logic [1:0] BAD   = 2'b10;

  // {raw_len, raw_bits, expected_len, expected_bits}; first bit is the MSB of the length
  localparam logic [47:0] VEC [5] = '{
    {8'd8,  16'h00B2, 8'd8,  16'h00B2},
    {8'd10, 16'h03FB, 8'd9,  16'h01FF},
    {8'd9,  16'h0002, 8'd8,  16'h0000},
    {8'd14, 16'h1555, 8'd14, 16'h1555},
    {8'd7,  16'h0068, 8'd7,  16'h0068}
  };

  always #5 clk = ~clk;

  mld_decoder i_mld_decoder (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
    .tok_class(tok_class), .tok_lvl(tok_lvl), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .bit_data(bit_data), .msg_start(msg_start),
    .abort_pulse(abort_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_acc();
    n_start = 0; n_abort = 0; ncap = 0; cap = '0;
  endtask

  task automatic send(input logic [1:0] c, input logic l);
    @(negedge clk);
    tok_valid = 1'b1; tok_class = c; tok_lvl = l;
    while (!tok_ready) @(negedge clk);
    @(posedge clk);
    #1;
    tok_valid = 1'b0;
    if (msg_start) n_start++;
    if (abort_pulse) n_abort++;
    if (bit_valid && bit_ready) begin
      cap = {cap[30:0], bit_data};
      ncap++;
    end
    cur_lvl = l;
  endtask

  task automatic send_longs(input int n);
    for (int i = 0; i < n; i++) send(LONG, !cur_lvl);
  endtask

  // preamble of 15 longs, padded by one so that it ends low
  task automatic send_pre();
    send_longs(15);
    if (cur_lvl) send_longs(1);
  endtask

  function automatic logic half_at(input logic [15:0] raw, input int len, input int k);
    int j;
    if (k < 2) return (k == 0);
    j = (k - 2) / 2;
    return ((k % 2) == 0) ? raw[len-1-j] : !raw[len-1-j];
  endfunction

  // start bit followed by raw bits, merged into short/long levels
  task automatic send_bits(input logic [15:0] raw, input int len);
    int total, run;
    logic rl, h;
    total = 2 + 2 * len;
    rl = half_at(raw, len, 0);
    run = 1;
    for (int k = 1; k < total; k++) begin
      h = half_at(raw, len, k);
      if (h == rl) run++;
      else begin
        send((run == 2) ? LONG : SHORT, rl);
        rl = h;
        run = 1;
      end
    end
    send((run == 2) ? LONG : SHORT, rl);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] mask;
    repeat (3) @(posedge clk);
    #1;
    chk(tok_ready == 1'b1 && bit_valid == 1'b0, "R1 reset outputs", bit_valid, 0);
    chk(msg_start == 1'b0 && abort_pulse == 1'b0, "R1 reset strobes", msg_start, 0);
    @(negedge clk); rst_n = 1'b1;

    // R3: 14 longs while hunting do not open a preamble
    clr_acc();
    send_longs(14);
    send(SHORT, 1'b1); send(SHORT, 1'b0);
    chk(n_start == 0, "R3 fourteen longs no preamble", n_start, 0);

    // R11: a short level splits the run
    clr_acc();
    send_longs(10); send(SHORT, !cur_lvl); send_longs(10);
    send(SHORT, !cur_lvl); send(SHORT, !cur_lvl); send(SHORT, !cur_lvl);
    chk(n_start == 0, "R11 split run no preamble", n_start, 0);

    // vector table: R3, R4, R5, R6
    foreach (VEC[v]) begin
      send_pre();
      clr_acc();
      send_bits(VEC[v][39:24], int'(VEC[v][47:40]));
      mask = (32'h1 << VEC[v][23:16]) - 1;
      chk(n_start == 1, "R4 start bit", n_start, 1);
      chk(ncap == int'(VEC[v][23:16]), "R6 bit count", ncap, int'(VEC[v][23:16]));
      chk((cap & mask) == {16'h0, VEC[v][15:0]}, "R5 bit values", int'(cap & mask), int'(VEC[v][15:0]));
      chk(n_abort == 0, "R12 no abort in clean frame", n_abort, 0);
    end

    // R6: stuffing violation
    send_pre(); clr_acc();
    send_bits(16'h00FF, 8);
    chk(n_abort == 1, "R6 stuff error aborts", n_abort, 1);
    chk(ncap == 7, "R6 bits before error", ncap, 7);

    // R7: preamble inside a message of alternating bits
    send_pre(); clr_acc();
    send(SHORT, 1'b1);
    send_longs(14);
    chk(n_start == 1 && n_abort == 0, "R5 fourteen longs in message", n_abort, 0);
    chk(ncap == 13, "R5 alternating bits", ncap, 13);
    send_longs(1);
    chk(n_abort == 1, "R7 abort on fifteenth long", n_abort, 1);
    send_pre(); clr_acc();
    send_bits(16'h00B2, 8);
    chk(n_start == 1 && ncap == 8 && cap[7:0] == 8'hB2, "R7 next message decodes", int'(cap[7:0]), 32'hB2);

    // R8 and R2: invalid code 2'b11 in a message, then 2'b10 while hunting
    clr_acc();
    send(2'b11, !cur_lvl);
    chk(n_abort == 1, "R8 R2 invalid in message", n_abort, 1);
    clr_acc();
    send(BAD, !cur_lvl);
    chk(n_abort == 0, "R8 invalid while hunting", n_abort, 1'b0);

    // R9: long level on a bit boundary
    send_pre(); clr_acc();
    send(SHORT, 1'b1); send(SHORT, 1'b0); send(LONG, 1'b1);
    chk(n_start == 1 && n_abort == 1, "R9 boundary long aborts", n_abort, 1);

    // R4: wrong polarity short ignored in preamble state
    send_longs(15);
    if (!cur_lvl) send_longs(1);
    clr_acc();
    send(SHORT, 1'b0);
    chk(n_start == 0 && n_abort == 0, "R4 wrong polarity ignored", n_start, 0);
    send(SHORT, 1'b1); send(SHORT, 1'b0);
    chk(n_start == 1, "R4 start after wrong short", n_start, 1);

    // R10: back-pressure
    send_pre();
    send(SHORT, 1'b1); send(SHORT, 1'b0);
    bit_ready = 1'b0;
    send(SHORT, 1'b1); send(SHORT, 1'b0);
    chk(bit_valid && bit_data == 1'b1 && !tok_ready, "R10 stall holds", tok_ready, 0);
    repeat (3) @(negedge clk);
    chk(bit_valid && bit_data == 1'b1 && !tok_ready, "R10 still held", bit_valid, 1);
    bit_ready = 1'b1;
    @(posedge clk); #1;
    chk(!bit_valid && tok_ready, "R10 release", bit_valid, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule